// File: doc/BRIEF.md
# Channel Digital Reset Sequencer

This block drives the digital reset lines of one transceiver channel, one direction at a time. A user command asks for a reset of the transmit side, the receive side, or both. For each direction the block runs two separate request/acknowledge handshakes with a shared arbiter. The first handshake puts the direction's bridge, FEC and PMA-interface resets into reset. The second handshake takes them out again. A request is raised only while the matching PMA reports ready.

Before the receive resets are released, the receiver must hold its locked-to-data status without a break for a configurable stability window. The default window is 180 µs, and any drop of lock starts the window again from zero. When the FEC is built in, a pending transmit reset always runs to completion before any receive reset begins. When the FEC is left out, the FEC reset lines stay low and either direction may go first. A one-cycle done pulse marks the end of each direction's release handshake.

Top module: `chan_rst_seq`

## Requirements
- R1: After reset, every reset output, `arb_req`, `tx_done` and `rx_done` are low.
- R2: `arb_req` rises for a transmit handshake only if `tx_pma_ready` was high in the cycle before. It rises for a receive handshake only if `rx_pma_ready` was high in the cycle before. While the needed ready is low, no request is raised.
- R3: In the assert handshake, the selected direction's bridge, FEC and PMA-interface resets all go high together. The other direction's resets do not change.
- R4: Releasing the resets takes its own, second request/acknowledge handshake, so a full one-direction sequence raises `arb_req` exactly twice.
- R5: Reset outputs change only on a clock edge at which `arb_ack` is high.
- R6: After `arb_req` drops, no new request is raised until `arb_ack` has been seen low.
- R7: With `USE_FEC`=1 and both directions pending, the transmit sequence, including its release and `tx_done`, completes before any receive reset rises. This holds even while `tx_pma_ready` is low.
- R8: The receive release request starts only after `rx_locked` has been high for `LOCK_NS`/`CLK_PERIOD_NS` consecutive cycles, counted from the end of the receive assert handshake. A drop of `rx_locked` restarts the count from zero.
- R9: With `USE_FEC`=0, `tx_fec_rst` and `rx_fec_rst` never rise. A pending receive reset whose PMA is ready proceeds while a pending transmit reset waits on `tx_pma_ready`.
- R10: `tx_done` and `rx_done` each pulse high for exactly one cycle after the release handshake of that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_rst_cmd | input | 1 | One-cycle command: reset the transmit side |
| rx_rst_cmd | input | 1 | One-cycle command: reset the receive side |
| tx_pma_ready | input | 1 | Transmit PMA ready |
| rx_pma_ready | input | 1 | Receive PMA ready |
| rx_locked | input | 1 | Receiver locked to data |
| arb_req | output | 1 | Request to the shared reset arbiter |
| arb_ack | input | 1 | Acknowledge from the arbiter |
| tx_bridge_rst | output | 1 | Transmit bridge reset |
| rx_bridge_rst | output | 1 | Receive bridge reset |
| tx_fec_rst | output | 1 | Transmit FEC reset |
| rx_fec_rst | output | 1 | Receive FEC reset |
| tx_pmaif_rst | output | 1 | Transmit PMA-interface reset |
| rx_pmaif_rst | output | 1 | Receive PMA-interface reset |
| tx_done | output | 1 | Transmit release complete pulse |
| rx_done | output | 1 | Receive release complete pulse |

## Verification
The bench builds two copies of the block. Both use a 4 ns clock period and a 96 ns lock window, which gives a 24-cycle stability count. This lets the full receive release, and a lock drop in the middle of the window, play out in a few dozen cycles instead of 45,000. One copy has `USE_FEC`=1 and carries the scoreboard for the transmit-before-receive ordering. The other has `USE_FEC`=0, which exposes the FEC-silent variant and the free ordering between directions.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } dir_e;

   typedef enum logic {
      PH_ASSERT  = 1'b0,
      PH_RELEASE = 1'b1
   } phase_e;

   typedef enum logic [1:0] {
      HS_IDLE,
      HS_REQ,
      HS_HOLD,
      HS_DROP
   } hs_state_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ARM,
      SQ_BUSY
   } sq_state_e;

   localparam int NUM_DIR = 2;

endpackage

// File: rtl/rst_hs_engine.sv
module rst_hs_engine
   import rst_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic ack_i,
   output logic req_o,
   output logic apply_o,
   output logic done_o
);

   hs_state_e state_q;
   logic      done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HS_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            HS_IDLE: if (start_i) state_q <= HS_REQ;
            HS_REQ:  if (ack_i)   state_q <= HS_HOLD;
            HS_HOLD: state_q <= HS_DROP;
            HS_DROP: if (!ack_i) begin
               state_q <= HS_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= HS_IDLE;
         endcase
      end
   end

   assign req_o   = (state_q == HS_REQ) || (state_q == HS_HOLD);
   assign apply_o = (state_q == HS_REQ) && ack_i;
   assign done_o  = done_q;

   // R6: a handshake ends only once the arbiter has let go of acknowledge
   a_r6_done_after_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !$past(ack_i));

endmodule

// File: rtl/rst_lock_timer.sv
module rst_lock_timer #(
   parameter int CNT_MAX = 45000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic locked_i,
   output logic stable_o
);

   localparam int CW = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] LIMIT = CW'(CNT_MAX);

   if (CNT_MAX < 1) begin : g_bad_limit
      $error("rst_lock_timer: CNT_MAX must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (clear_i || !locked_i) cnt_q <= '0;
      else if (cnt_q != LIMIT)       cnt_q <= cnt_q + 1'b1;
   end

   assign stable_o = (cnt_q == LIMIT);

   // R8: losing lock always withdraws stability on the next cycle
   a_r8_drop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      !locked_i |=> !stable_o);

endmodule

// File: rtl/rst_out_bank.sv
module rst_out_bank
   import rst_seq_pkg::*;
#(
   parameter bit USE_FEC = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               apply_i,
   input  dir_e               dir_i,
   input  phase_e             phase_i,
   output logic [NUM_DIR-1:0] bridge_o,
   output logic [NUM_DIR-1:0] fec_o,
   output logic [NUM_DIR-1:0] pmaif_o
);

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      logic hit;
      logic level;
      logic bridge_q;
      logic pmaif_q;

      assign hit   = apply_i && (dir_i == dir_e'(d));
      assign level = (phase_i == PH_ASSERT);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bridge_q <= 1'b0;
            pmaif_q  <= 1'b0;
         end else if (hit) begin
            bridge_q <= level;
            pmaif_q  <= level;
         end
      end

      assign bridge_o[d] = bridge_q;
      assign pmaif_o[d]  = pmaif_q;

      if (USE_FEC) begin : g_fec
         logic fec_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   fec_q <= 1'b0;
            else if (hit) fec_q <= level;
         end
         assign fec_o[d] = fec_q;
      end else begin : g_no_fec
         assign fec_o[d] = 1'b0;
      end

      // R3: reset lines rise only in an assert handshake
      a_r3_rise_on_assert: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(bridge_o[d]) |-> $past(phase_i == PH_ASSERT));
   end

endmodule

// File: rtl/chan_rst_seq.sv
module chan_rst_seq
   import rst_seq_pkg::*;
#(
   parameter bit USE_FEC       = 1'b1,
   parameter int CLK_PERIOD_NS = 4,
   parameter int LOCK_NS       = 180000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_rst_cmd,
   input  logic rx_rst_cmd,
   input  logic tx_pma_ready,
   input  logic rx_pma_ready,
   input  logic rx_locked,
   output logic arb_req,
   input  logic arb_ack,
   output logic tx_bridge_rst,
   output logic rx_bridge_rst,
   output logic tx_fec_rst,
   output logic rx_fec_rst,
   output logic tx_pmaif_rst,
   output logic rx_pmaif_rst,
   output logic tx_done,
   output logic rx_done
);

   localparam int LOCK_CYCLES = (LOCK_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("chan_rst_seq: CLK_PERIOD_NS must be positive");
   end
   if (LOCK_NS < 1) begin : g_bad_lock
      $error("chan_rst_seq: LOCK_NS must be positive");
   end

   sq_state_e sq_q;
   dir_e      dir_q;
   phase_e    phase_q;
   logic      pend_tx_q, pend_rx_q;
   logic      tx_done_q, rx_done_q;

   logic      pick_valid;
   dir_e      pick_dir;
   logic      gate;
   logic      eng_start, eng_apply, eng_done;
   logic      lock_stable, lock_clr;
   logic      fin_tx, fin_rx;

   logic [NUM_DIR-1:0] bridge_v, fec_v, pmaif_v;

   // Direction selection: ordered when the FEC is present, readiness-driven otherwise
   if (USE_FEC) begin : g_sel_ordered
      assign pick_valid = pend_tx_q || pend_rx_q;
      assign pick_dir   = pend_tx_q ? DIR_TX : DIR_RX;
   end else begin : g_sel_free
      logic tx_go, rx_go;
      assign tx_go      = pend_tx_q && tx_pma_ready;
      assign rx_go      = pend_rx_q && rx_pma_ready;
      assign pick_valid = tx_go || rx_go;
      assign pick_dir   = tx_go ? DIR_TX : DIR_RX;
   end

   always_comb begin
      if (dir_q == DIR_TX) gate = tx_pma_ready;
      else                 gate = rx_pma_ready && ((phase_q == PH_ASSERT) || lock_stable);
   end

   assign eng_start = (sq_q == SQ_ARM) && gate && !arb_ack;
   assign lock_clr  = (sq_q == SQ_BUSY) && eng_done && (phase_q == PH_ASSERT) && (dir_q == DIR_RX);
   assign fin_tx    = (sq_q == SQ_BUSY) && eng_done && (phase_q == PH_RELEASE) && (dir_q == DIR_TX);
   assign fin_rx    = (sq_q == SQ_BUSY) && eng_done && (phase_q == PH_RELEASE) && (dir_q == DIR_RX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq_q      <= SQ_IDLE;
         dir_q     <= DIR_TX;
         phase_q   <= PH_ASSERT;
         pend_tx_q <= 1'b0;
         pend_rx_q <= 1'b0;
         tx_done_q <= 1'b0;
         rx_done_q <= 1'b0;
      end else begin
         pend_tx_q <= (pend_tx_q && !fin_tx) || tx_rst_cmd;
         pend_rx_q <= (pend_rx_q && !fin_rx) || rx_rst_cmd;
         tx_done_q <= fin_tx;
         rx_done_q <= fin_rx;
         unique case (sq_q)
            SQ_IDLE: if (pick_valid) begin
               sq_q    <= SQ_ARM;
               dir_q   <= pick_dir;
               phase_q <= PH_ASSERT;
            end
            SQ_ARM: if (eng_start) sq_q <= SQ_BUSY;
            SQ_BUSY: if (eng_done) begin
               if (phase_q == PH_ASSERT) begin
                  phase_q <= PH_RELEASE;
                  sq_q    <= SQ_ARM;
               end else begin
                  sq_q <= SQ_IDLE;
               end
            end
            default: sq_q <= SQ_IDLE;
         endcase
      end
   end

   rst_hs_engine i_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (eng_start),
      .ack_i   (arb_ack),
      .req_o   (arb_req),
      .apply_o (eng_apply),
      .done_o  (eng_done)
   );

   rst_lock_timer #(.CNT_MAX(LOCK_CYCLES)) i_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (lock_clr),
      .locked_i (rx_locked),
      .stable_o (lock_stable)
   );

   rst_out_bank #(.USE_FEC(USE_FEC)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .apply_i  (eng_apply),
      .dir_i    (dir_q),
      .phase_i  (phase_q),
      .bridge_o (bridge_v),
      .fec_o    (fec_v),
      .pmaif_o  (pmaif_v)
   );

   assign tx_bridge_rst = bridge_v[DIR_TX];
   assign rx_bridge_rst = bridge_v[DIR_RX];
   assign tx_fec_rst    = fec_v[DIR_TX];
   assign rx_fec_rst    = fec_v[DIR_RX];
   assign tx_pmaif_rst  = pmaif_v[DIR_TX];
   assign rx_pmaif_rst  = pmaif_v[DIR_RX];
   assign tx_done       = tx_done_q;
   assign rx_done       = rx_done_q;

   logic [5:0] rst_vec;
   assign rst_vec = {rx_pmaif_rst, rx_fec_rst, rx_bridge_rst,
                     tx_pmaif_rst, tx_fec_rst, tx_bridge_rst};

   // R2: a request rises only behind the matching PMA ready
   a_r2_ready_gates_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_req) |-> ((dir_q == DIR_TX) ? $past(tx_pma_ready) : $past(rx_pma_ready)));

   // R5: outputs move only under an acknowledge
   a_r5_change_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_vec != $past(rst_vec)) |-> $past(arb_ack));

   // R6: no fresh request while acknowledge is still high
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_req) |-> !$past(arb_ack));

   // R8: receive release request only after the lock window
   a_r8_release_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(arb_req) && dir_q == DIR_RX && phase_q == PH_RELEASE) |-> $past(lock_stable));

   // R10: completion pulses last one cycle
   a_r10_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !tx_done);
   a_r10_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   if (USE_FEC) begin : g_order_chk
      // R7: receive side enters reset only with the transmit side already out of it
      a_r7_tx_before_rx: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rx_bridge_rst) |-> !tx_bridge_rst);
   end

endmodule

// File: tb/test_chan_rst_seq.sv
module test_chan_rst_seq;

   localparam int LOCK = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // FEC-enabled instance
   logic f_txc = 0, f_rxc = 0, f_txr = 1, f_rxr = 1, f_lock = 1, f_ack = 0;
   logic f_req, f_txb, f_rxb, f_txf, f_rxf, f_txp, f_rxp, f_txd, f_rxd;
   // FEC-less instance
   logic n_txc = 0, n_rxc = 0, n_txr = 1, n_rxr = 1, n_lock = 1, n_ack = 0;
   logic n_req, n_txb, n_rxb, n_txf, n_rxf, n_txp, n_rxp, n_txd, n_rxd;

   chan_rst_seq #(.USE_FEC(1'b1), .CLK_PERIOD_NS(4), .LOCK_NS(96)) i_chan_rst_seq (
      .clk(clk), .rst_n(rst_n), .tx_rst_cmd(f_txc), .rx_rst_cmd(f_rxc),
      .tx_pma_ready(f_txr), .rx_pma_ready(f_rxr), .rx_locked(f_lock),
      .arb_req(f_req), .arb_ack(f_ack),
      .tx_bridge_rst(f_txb), .rx_bridge_rst(f_rxb), .tx_fec_rst(f_txf), .rx_fec_rst(f_rxf),
      .tx_pmaif_rst(f_txp), .rx_pmaif_rst(f_rxp), .tx_done(f_txd), .rx_done(f_rxd));

   chan_rst_seq #(.USE_FEC(1'b0), .CLK_PERIOD_NS(4), .LOCK_NS(96)) i_chan_rst_seq_nofec (
      .clk(clk), .rst_n(rst_n), .tx_rst_cmd(n_txc), .rx_rst_cmd(n_rxc),
      .tx_pma_ready(n_txr), .rx_pma_ready(n_rxr), .rx_locked(n_lock),
      .arb_req(n_req), .arb_ack(n_ack),
      .tx_bridge_rst(n_txb), .rx_bridge_rst(n_rxb), .tx_fec_rst(n_txf), .rx_fec_rst(n_rxf),
      .tx_pmaif_rst(n_txp), .rx_pmaif_rst(n_rxp), .tx_done(n_txd), .rx_done(n_rxd));

   // Arbiter models: acknowledge follows request three cycles late
   logic [2:0] f_hist = '0, n_hist = '0;
   initial forever begin
      @(negedge clk);
      f_hist = {f_hist[1:0], f_req};
      n_hist = {n_hist[1:0], n_req};
      f_ack  = rst_n && f_hist[2];
      n_ack  = rst_n && n_hist[2];
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Scoreboard: tag 0 = reset vector change, 1 = tx done, 2 = rx done
   logic [7:0] exp_q[$];
   localparam logic [5:0] V_TX = 6'b000111;
   localparam logic [5:0] V_RX = 6'b111000;

   task automatic push(input logic [1:0] tag, input logic [5:0] v);
      exp_q.push_back({tag, v});
   endtask

   int f_req_rises = 0;
   int f_txd_cnt = 0, f_rxd_cnt = 0, n_txd_cnt = 0, n_rxd_cnt = 0;
   int rx_rel_cyc = 0;
   bit n_fec_seen = 0;

   task automatic observe(input logic [7:0] got, input string req);
      logic [7:0] exp;
      if (exp_q.size() == 0) begin
         check(1'b0, {req, " unexpected event"}, got, 0);
      end else begin
         exp = exp_q.pop_front();
         check(got == exp, req, got, exp);
      end
   endtask

   initial begin
      logic [5:0] prev = '0;
      logic       prev_req = 1'b0;
      logic [5:0] v;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            v = {f_rxp, f_rxf, f_rxb, f_txp, f_txf, f_txb};
            if (v != prev) begin
               observe({2'd0, v}, "R3/R7 reset vector");
               if (prev[3] && !v[3]) rx_rel_cyc = cyc;
            end
            if (f_txd) begin observe({2'd1, 6'd0}, "R10 tx_done"); f_txd_cnt++; end
            if (f_rxd) begin observe({2'd2, 6'd0}, "R10 rx_done"); f_rxd_cnt++; end
            if (f_req && !prev_req) f_req_rises++;
            prev = v;
            prev_req = f_req;
            if (n_txf || n_rxf) n_fec_seen = 1;
            if (n_txd) n_txd_cnt++;
            if (n_rxd) n_rxd_cnt++;
         end
      end
   end

   task automatic pulse_f(input bit tx, input bit rx);
      @(negedge clk); f_txc = tx; f_rxc = rx;
      @(negedge clk); f_txc = 0;  f_rxc = 0;
   endtask

   task automatic run_all();
      int r0, relock;
      repeat (3) @(negedge clk);
      check({f_req, f_txb, f_rxb, f_txf, f_rxf, f_txp, f_rxp, f_txd, f_rxd} == 0,
            "R1 reset state fec", {f_req, f_txb, f_rxb}, 0);
      check({n_req, n_txb, n_rxb, n_txf, n_rxf, n_txp, n_rxp, n_txd, n_rxd} == 0,
            "R1 reset state nofec", {n_req, n_txb, n_rxb}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // TX only: two handshakes (R3, R4, R10)
      push(0, V_TX); push(0, 0); push(1, 0);
      r0 = f_req_rises;
      pulse_f(1, 0);
      while (f_txd_cnt < 1) @(negedge clk);
      repeat (5) @(negedge clk);
      check(f_req_rises - r0 == 2, "R4 two handshakes per sequence", f_req_rises - r0, 2);

      // Both with TX PMA not ready: nothing moves, then TX fully before RX (R2, R7)
      f_txr = 0;
      push(0, V_TX); push(0, 0); push(1, 0); push(0, V_RX); push(0, 0); push(2, 0);
      pulse_f(1, 1);
      repeat (40) @(negedge clk);
      check(f_req == 0, "R2 no request while tx pma not ready", f_req, 0);
      check({f_rxb, f_rxp, f_rxf} == 0, "R7 rx waits for tx", {f_rxb, f_rxp, f_rxf}, 0);
      f_txr = 1;
      while (f_rxd_cnt < 1) @(negedge clk);

      // RX with a lock drop in the window (R8)
      push(0, V_RX); push(0, 0); push(2, 0);
      pulse_f(0, 1);
      while (!f_rxb) @(negedge clk);
      repeat (20) @(negedge clk);
      f_lock = 0;
      repeat (2) @(negedge clk);
      f_lock = 1;
      relock = cyc;
      repeat (LOCK - 4) @(negedge clk);
      check(f_rxb == 1, "R8 rx still held after lock drop", f_rxb, 1);
      while (f_rxd_cnt < 2) @(negedge clk);
      check(rx_rel_cyc - relock >= LOCK, "R8 release after full window",
            rx_rel_cyc - relock, LOCK);

      // RX PMA not ready gates request (R2)
      f_rxr = 0;
      push(0, V_RX); push(0, 0); push(2, 0);
      pulse_f(0, 1);
      repeat (30) @(negedge clk);
      check(f_req == 0, "R2 no request while rx pma not ready", f_req, 0);
      f_rxr = 1;
      while (f_rxd_cnt < 3) @(negedge clk);
      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R10 all expected events seen", exp_q.size(), 0);

      // FEC-less: RX goes first while TX waits on PMA ready (R9)
      n_txr = 0;
      @(negedge clk); n_txc = 1; n_rxc = 1;
      @(negedge clk); n_txc = 0; n_rxc = 0;
      while (!n_rxb) @(negedge clk);
      check(n_txb == 0, "R9 rx proceeds ahead of tx", n_txb, 0);
      check(n_rxp == 1, "R9 rx pma-if reset with bridge", n_rxp, 1);
      n_txr = 1;
      while (n_txd_cnt < 1 || n_rxd_cnt < 1) @(negedge clk);
      check(n_rxd_cnt == 1 && n_txd_cnt == 1, "R10 one pulse per direction",
            n_rxd_cnt + n_txd_cnt, 2);
      check(!n_fec_seen, "R9 fec resets stay low", n_fec_seen, 0);
      check({n_txb, n_rxb, n_txp, n_rxp} == 0, "R9 all released", {n_txb, n_rxb, n_txp, n_rxp}, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule